// File: doc/BRIEF.md
# Nickel-and-Dime Gum Dispenser Controller

This controller runs a gum dispenser with a single coin slot. The slot takes nickels, worth 5 cents, and dimes, worth 10 cents. Each coin arrives as a pulse lasting one cycle. The controller adds up the credit. When the credit reaches the 15-cent price or goes past it, the controller enters a vend state. In that state the `vend_open` output is high for exactly one cycle, and the controller then returns to zero credit. It never gives change, so any overpayment is lost.

The state register has two bits, built from D flip-flops, and is cleared by reset. Credit states are shared by amount: 0, 5 and 10 cents, plus one state for 15 cents or more. The output depends only on the state, so it is a Moore output.

Top module: `gum_vend_ctrl`

## Requirements
- R1: After reset the state is zero credit (code 2'b00), and `vend_open` is low.
- R2: The state codes are: 0c = 2'b00, 5c = 2'b01, 10c = 2'b10, 15c-or-more = 2'b11. `vend_open` is high exactly when the state is 2'b11.
- R3: A nickel (`coin_nickel`=1, `coin_dime`=0) moves the state from 0c to 5c, from 5c to 10c, and from 10c to vend.
- R4: A dime (`coin_dime`=1, `coin_nickel`=0) moves the state from 0c to 10c, from 5c to vend, and from 10c to vend. The excess from 10c+10 is discarded.
- R5: In a cycle with no coin, the credit state is held.
- R6: When both coin inputs are high in the same cycle, the cycle counts as no coin and the state is held.
- R7: The vend state always moves to 0c on the next cycle. Any coin input during that cycle is ignored, so `vend_open` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, forces 0c |
| coin_nickel | input | 1 | One-cycle pulse for a 5-cent coin |
| coin_dime | input | 1 | One-cycle pulse for a 10-cent coin |
| vend_open | output | 1 | High while in the vend state |
| credit_state | output | 2 | Current state code (see R2) |

## Verification
A wrong stored credit appears at `credit_state` on the edge right after the bad transition. A wrong transition into or out of vend appears on `vend_open` in that same cycle. A lost or extra credit step may only show on `vend_open` one or two coins later, so the bench compares the state on every cycle instead of waiting for the vend output. Since `credit_state` is checked against an integer credit model each cycle, any difference is caught at once.

// File: rtl/gum_vend_pkg.sv
package gum_vend_pkg;
  localparam int unsigned PRICE_CENTS  = 15;
  localparam int unsigned NICKEL_CENTS = 5;
  localparam int unsigned DIME_CENTS   = 10;
  localparam int unsigned STATE_W      = 2;

  typedef enum logic [STATE_W-1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_VEND = 2'b11
  } credit_e;

  function automatic int unsigned state_cents(credit_e s);
    case (s)
      CR_FIVE: return NICKEL_CENTS;
      CR_TEN:  return DIME_CENTS;
      CR_VEND: return PRICE_CENTS;
      default: return 0;
    endcase
  endfunction

  function automatic credit_e cents_state(int unsigned c);
    if (c >= PRICE_CENTS)       return CR_VEND;
    else if (c >= DIME_CENTS)   return CR_TEN;
    else if (c >= NICKEL_CENTS) return CR_FIVE;
    else                        return CR_ZERO;
  endfunction
endpackage

// File: rtl/gum_coin_decode.sv
module gum_coin_decode (
  input  logic       nickel,
  input  logic       dime,
  output logic [4:0] coin_cents,
  output logic       coin_valid
);
  import gum_vend_pkg::*;
  always_comb begin
    coin_valid = nickel ^ dime;
    coin_cents = '0;
    if (nickel && !dime)      coin_cents = 5'(NICKEL_CENTS);
    else if (dime && !nickel) coin_cents = 5'(DIME_CENTS);
  end
endmodule

// File: rtl/gum_next_state.sv
module gum_next_state
  import gum_vend_pkg::*;
(
  input  credit_e    cur,
  input  logic [4:0] coin_cents,
  input  logic       coin_valid,
  output credit_e    nxt
);
  always_comb begin
    if (cur == CR_VEND)  nxt = CR_ZERO;
    else if (coin_valid) nxt = cents_state(state_cents(cur) + int'(coin_cents));
    else                 nxt = cur;
  end
endmodule

// File: rtl/gum_vend_ctrl.sv
module gum_vend_ctrl
  import gum_vend_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               coin_nickel,
  input  logic               coin_dime,
  output logic               vend_open,
  output logic [STATE_W-1:0] credit_state
);
  credit_e    state_q, state_d;
  logic [4:0] coin_cents;
  logic       coin_valid;
  logic       dual_coin;

  assign dual_coin = coin_nickel & coin_dime;

  gum_coin_decode u_decode (
    .nickel(coin_nickel), .dime(coin_dime),
    .coin_cents(coin_cents), .coin_valid(coin_valid)
  );

  gum_next_state u_next (
    .cur(state_q), .coin_cents(coin_cents),
    .coin_valid(coin_valid), .nxt(state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= CR_ZERO;
    else     state_q <= state_d;
  end

  assign vend_open    = (state_q == CR_VEND);
  assign credit_state = state_q;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (credit_state == 2'b00 && !vend_open));
  assert_vend_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    vend_open |=> (credit_state == 2'b00));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!coin_nickel && !coin_dime && !vend_open) |=> $stable(credit_state));
  assert_dual_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (dual_coin && !vend_open) |=> $stable(credit_state));
  assert_dime_from_five_R4: assert property (@(posedge clk) disable iff (rst)
    (coin_dime && !coin_nickel && credit_state == 2'b01) |=> vend_open);
  assert_nickel_from_ten_R3: assert property (@(posedge clk) disable iff (rst)
    (coin_nickel && !coin_dime && credit_state == 2'b10) |=> vend_open);
  assert_open_moore_R2: assert property (@(posedge clk) disable iff (rst)
    vend_open |-> (credit_state == 2'b11));
endmodule

// File: tb/gum_vend_ctrl_bench.sv
module gum_vend_ctrl_bench;
  logic clk = 0, rst = 1, nk = 0, dm = 0;
  logic vend_open;
  logic [1:0] credit_state;
  int checks = 0, errors = 0;
  int credit = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gum_vend_ctrl u_gum_vend_ctrl (
    .clk(clk), .rst(rst), .coin_nickel(nk), .coin_dime(dm),
    .vend_open(vend_open), .credit_state(credit_state));

  function automatic logic [1:0] code_of(int c);
    return (c >= 15) ? 2'b11 : (c >= 10) ? 2'b10 : (c >= 5) ? 2'b01 : 2'b00;
  endfunction

  task automatic check(string req, logic [1:0] exp_st);
    checks++;
    if (credit_state !== exp_st || vend_open !== (exp_st == 2'b11)) begin
      errors++;
      $display("FAIL %s: state=%b open=%b expected state=%b open=%b",
               req, credit_state, vend_open, exp_st, exp_st == 2'b11);
    end
  endtask

  task automatic step(logic n, logic d, string req);
    nk = n; dm = d;
    @(posedge clk);
    if (credit >= 15) credit = 0;
    else if (n ^ d) credit = credit + (n ? 5 : 10);
    #1 nk = 0; dm = 0;
    check(req, code_of(credit));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 2'b00);
    rst = 0;
    step(0, 0, "R5");
    step(1, 0, "R3"); step(0, 0, "R5"); step(1, 0, "R3"); step(1, 0, "R3 R2");
    step(1, 0, "R7");
    step(0, 1, "R4"); step(0, 1, "R4 overpay"); step(0, 1, "R7 dime ignored");
    step(1, 0, "R3"); step(0, 1, "R4"); step(0, 0, "R7");
    step(0, 1, "R4"); step(1, 0, "R3"); step(0, 0, "R7");
    step(1, 1, "R6"); step(1, 0, "R3"); step(1, 1, "R6"); step(0, 0, "R5");
    step(0, 1, "R4"); step(1, 1, "R7 dual in vend");
    for (int i = 0; i < 200; i++) begin
      logic n, d;
      n = 1'($urandom_range(0, 1)); d = 1'($urandom_range(0, 1));
      step(n, d, "R3 R4 R5 R6 R7 random");
    end
    nk = 1; @(posedge clk); #1 nk = 0;
    rst = 1; @(posedge clk); #1 rst = 0; credit = 0;
    check("R1 midrun", 2'b00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk);
        errors++; $display("FAIL watchdog: actual hang expected finish"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule